// File: doc/BRIEF.md
# DDR Write and Command Launch

This block is the transmit half of a DDR-1 SDRAM physical layer, modelled at register-transfer level. A controller hands it one command at a time: an opcode, an address, a burst-length code and the full set of write beats. The block drives the memory clock, the registered command and address lines, the write data bus and the data strobe. It also drives separate output enables for data and strobe, because the strobe pin is shared with reads and must float whenever no write is in flight.

The four phase clocks (0, 90, 180 and 270 degrees) come from one source. Here they are the four consecutive quarters of one memory-clock period. The input `clk` runs four times faster than the memory clock, and a free-running quarter counter says which phase owns the next edge. The memory clock is high for quarters 0 and 1 and low for quarters 2 and 3. Command and address change only on the 180-degree quarter. Data beats change only on the 90 and 270-degree quarters. The strobe toggles on the 0 and 180-degree quarters, so each strobe edge falls in the middle of a data beat.

The sequencer has six states. ST_IDLE takes a command (IDLE to ALIGN). ST_ALIGN waits for the next 180-degree quarter and launches the command. From there a write goes to ST_PRE and any other opcode goes to ST_HOLD. ST_HOLD keeps the command up for one memory clock and then returns to IDLE. ST_PRE turns the outputs on with the strobe low. It moves to ST_BURST when the first beat is launched. ST_BURST alternates between loading beats and toggling the strobe. It moves to ST_POST on the last strobe edge. ST_POST holds the strobe low for half a memory clock, then drops both enables and returns to IDLE.

Top module: `ddr_wr_launch`

## Requirements
- R1: While reset is held, the outputs read as follows: mem_cmd is NOP (3'b111), mem_ck is 0, dqs_o is 0, and both dq_oe and dqs_oe are 0.
- R2: mem_ck has a period of four clk cycles. It is high for two and low for two, and the first cycle after reset is high.
- R3: mem_cmd and mem_addr change only in the clk cycle where mem_ck falls. A launched command stays on mem_cmd for exactly four clk cycles and then returns to NOP.
- R4: A non-write command (any opcode other than 3'b100) appears once on mem_cmd with its address. It produces no strobe and no output enable.
- R5: For a write (opcode 3'b100), dqs_oe rises two clk cycles after the command appears on mem_cmd, with dqs_o low. The strobe then stays low for four clk cycles (one memory clock) before its first edge.
- R6: dqs_o changes only in cycles where mem_ck changes. A write produces exactly as many strobe edges as beats, and the first edge is rising. Burst code 0 means 2 beats, code 1 means 4, and codes 2 and 3 mean 8.
- R7: dq_o changes only in cycles where mem_ck holds its level (the quarter-offset phases). At the k-th strobe edge, dq_o equals cmd_wdata[k*DQ_W +: DQ_W] as captured when the command was taken.
- R8: After the last strobe edge, dqs_o stays low for two clk cycles (half a memory clock). Then dqs_oe and dq_oe fall together.
- R9: dq_oe always equals dqs_oe. Both are low outside a write window, and dqs_o is low whenever dqs_oe is low.
- R10: cmd_valid is ignored in any cycle where the block is not in ST_IDLE. No extra command reaches mem_cmd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Quarter-phase clock, four cycles per memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is offered this cycle |
| cmd_op | input | 3 | Opcode; 3'b100 is write, 3'b111 is NOP |
| cmd_addr | input | ADDR_W | Address that goes with the command |
| cmd_bl | input | 2 | Burst code: 0 gives 2 beats, 1 gives 4, 2 or 3 give 8 |
| cmd_wdata | input | 8*DQ_W | Write beats, beat k in bits [k*DQ_W +: DQ_W] |
| mem_ck | output | 1 | Memory clock |
| mem_cmd | output | 3 | Registered command lines |
| mem_addr | output | ADDR_W | Registered address lines |
| dq_o | output | DQ_W | Write data to the pad |
| dq_oe | output | 1 | Data output enable |
| dqs_o | output | 1 | Strobe value to the pad |
| dqs_oe | output | 1 | Strobe output enable |

## Verification
The properties assume that opcodes arrive only as single-cycle cmd_valid pulses. They also assume the controller does not rely on a command being taken while a previous one is still being sequenced. The bench spaces its commands so that each burst ends before the next is offered. The one exception is a deliberate offer made in the middle of a burst, and for that offer the scoreboard expects nothing on mem_cmd. The scoreboard works out the expected beat at each strobe edge, and the quarter counts around each window, from the burst code and the data supplied. It does not look at the design's internal state.

// File: rtl/ddr_tx_pkg.sv
`timescale 1ns/1ps
package ddr_tx_pkg;

    localparam int MAX_BEATS = 8;
    localparam int BIW       = $clog2(MAX_BEATS);
    localparam int QW        = $clog2(6 + 2 * MAX_BEATS + 1);

    typedef enum logic [2:0] {
        OP_MRS = 3'b000,
        OP_REF = 3'b001,
        OP_PRE = 3'b010,
        OP_ACT = 3'b011,
        OP_WR  = 3'b100,
        OP_RD  = 3'b101,
        OP_BST = 3'b110,
        OP_NOP = 3'b111
    } mem_op_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALIGN,
        ST_HOLD,
        ST_PRE,
        ST_BURST,
        ST_POST
    } seq_st_t;

    function automatic logic [3:0] beats_of(input logic [1:0] code);
        unique case (code)
            2'd0:    return 4'd2;
            2'd1:    return 4'd4;
            default: return 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/ddr_tx_phase.sv
`timescale 1ns/1ps
module ddr_tx_phase (
    input  logic       clk,
    input  logic       rst_n,
    output logic [1:0] ph_next,
    output logic       mem_ck
);
    logic [1:0] ph;

    assign ph_next = ph + 2'd1;

    // quarters 0 and 1 drive the high half, 2 and 3 the low half
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph     <= 2'd3;
            mem_ck <= 1'b0;
        end else begin
            ph     <= ph_next;
            mem_ck <= ~ph_next[1];
        end
    end
endmodule

// File: rtl/ddr_tx_seq.sv
`timescale 1ns/1ps
module ddr_tx_seq
    import ddr_tx_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic [2:0]     cmd_op,
    input  logic [1:0]     cmd_bl,
    input  logic [1:0]     ph_next,
    output logic           accept,
    output logic           launch,
    output logic           drop,
    output logic           oe_on,
    output logic           oe_off,
    output logic           beat_load,
    output logic [BIW-1:0] beat_idx,
    output logic           dqs_tgl
);
    seq_st_t         state, nxt;
    logic [QW-1:0]   qc;
    logic [QW-1:0]   qc_n;
    logic            is_wr;
    logic [3:0]      nbeats;
    logic [QW-1:0]   nb2;
    logic [QW-1:0]   q_last_edge;
    logic [QW-1:0]   q_end;

    assign qc_n        = qc + QW'(1);
    assign nb2         = QW'({nbeats, 1'b0});
    assign q_last_edge = nb2 + QW'(4);
    assign q_end       = nb2 + QW'(6);
    assign beat_idx    = beat_ptr;

    logic [BIW-1:0] beat_ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            qc       <= '0;
            is_wr    <= 1'b0;
            nbeats   <= 4'd2;
            beat_ptr <= '0;
        end else begin
            state <= nxt;
            if (accept) begin
                is_wr  <= (cmd_op == OP_WR);
                nbeats <= beats_of(cmd_bl);
            end
            if (launch) begin
                qc       <= '0;
                beat_ptr <= '0;
            end else if (state != ST_IDLE && state != ST_ALIGN) begin
                qc <= qc_n;
            end
            if (beat_load) beat_ptr <= beat_ptr + BIW'(1);
        end
    end

    always_comb begin
        nxt       = state;
        accept    = 1'b0;
        launch    = 1'b0;
        drop      = 1'b0;
        oe_on     = 1'b0;
        oe_off    = 1'b0;
        beat_load = 1'b0;
        dqs_tgl   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    accept = 1'b1;
                    nxt    = ST_ALIGN;
                end
            end
            ST_ALIGN: begin
                if (ph_next == 2'd2) begin
                    launch = 1'b1;
                    nxt    = is_wr ? ST_PRE : ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (qc_n == QW'(4)) begin
                    drop = 1'b1;
                    nxt  = ST_IDLE;
                end
            end
            ST_PRE: begin
                if (qc_n == QW'(2)) oe_on = 1'b1;
                if (qc_n == QW'(4)) drop  = 1'b1;
                if (qc_n == QW'(5)) begin
                    beat_load = 1'b1;
                    nxt       = ST_BURST;
                end
            end
            ST_BURST: begin
                if (qc_n[0]) beat_load = 1'b1;
                else         dqs_tgl   = 1'b1;
                if (qc_n == q_last_edge) nxt = ST_POST;
            end
            ST_POST: begin
                if (qc_n == q_end) begin
                    oe_off = 1'b1;
                    nxt    = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/ddr_tx_cmd.sv
`timescale 1ns/1ps
module ddr_tx_cmd
    import ddr_tx_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              launch,
    input  logic              drop,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic [2:0]        mem_cmd,
    output logic [ADDR_W-1:0] mem_addr
);
    logic [2:0]        op_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_NOP;
            addr_q   <= '0;
            mem_cmd  <= OP_NOP;
            mem_addr <= '0;
        end else begin
            if (accept) begin
                op_q   <= cmd_op;
                addr_q <= cmd_addr;
            end
            // launch and drop only fire on the 180-degree quarter
            if (launch) begin
                mem_cmd  <= op_q;
                mem_addr <= addr_q;
            end else if (drop) begin
                mem_cmd  <= OP_NOP;
            end
        end
    end
endmodule

// File: rtl/ddr_tx_wpath.sv
`timescale 1ns/1ps
module ddr_tx_wpath
    import ddr_tx_pkg::*;
#(
    parameter int DQ_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      accept,
    input  logic [MAX_BEATS*DQ_W-1:0] cmd_wdata,
    input  logic                      oe_on,
    input  logic                      oe_off,
    input  logic                      beat_load,
    input  logic [BIW-1:0]            beat_idx,
    input  logic                      dqs_tgl,
    output logic [DQ_W-1:0]           dq_o,
    output logic                      dq_oe,
    output logic                      dqs_o,
    output logic                      dqs_oe
);
    logic [DQ_W-1:0] beats [MAX_BEATS];

    for (genvar g = 0; g < MAX_BEATS; g++) begin : g_beat
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      beats[g] <= '0;
            else if (accept) beats[g] <= cmd_wdata[g*DQ_W +: DQ_W];
        end
    end

    // data register: loads only on the 90 and 270-degree quarters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dq_o  <= '0;
            dq_oe <= 1'b0;
        end else begin
            if (beat_load) dq_o <= beats[beat_idx];
            if (oe_on)       dq_oe <= 1'b1;
            else if (oe_off) dq_oe <= 1'b0;
        end
    end

    // strobe register: toggles only on the 0 and 180-degree quarters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dqs_o  <= 1'b0;
            dqs_oe <= 1'b0;
        end else begin
            if (oe_on) begin
                dqs_oe <= 1'b1;
                dqs_o  <= 1'b0;
            end else if (oe_off) begin
                dqs_oe <= 1'b0;
                dqs_o  <= 1'b0;
            end else if (dqs_tgl) begin
                dqs_o  <= ~dqs_o;
            end
        end
    end
endmodule

// File: rtl/ddr_wr_launch.sv
`timescale 1ns/1ps
module ddr_wr_launch
    import ddr_tx_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DQ_W   = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_valid,
    input  logic [2:0]                cmd_op,
    input  logic [ADDR_W-1:0]         cmd_addr,
    input  logic [1:0]                cmd_bl,
    input  logic [MAX_BEATS*DQ_W-1:0] cmd_wdata,
    output logic                      mem_ck,
    output logic [2:0]                mem_cmd,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [DQ_W-1:0]           dq_o,
    output logic                      dq_oe,
    output logic                      dqs_o,
    output logic                      dqs_oe
);
    logic [1:0]     ph_next;
    logic           accept, launch, drop, oe_on, oe_off, beat_load, dqs_tgl;
    logic [BIW-1:0] beat_idx;

    ddr_tx_phase u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .ph_next (ph_next),
        .mem_ck  (mem_ck)
    );

    ddr_tx_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_bl    (cmd_bl),
        .ph_next   (ph_next),
        .accept    (accept),
        .launch    (launch),
        .drop      (drop),
        .oe_on     (oe_on),
        .oe_off    (oe_off),
        .beat_load (beat_load),
        .beat_idx  (beat_idx),
        .dqs_tgl   (dqs_tgl)
    );

    ddr_tx_cmd #(.ADDR_W(ADDR_W)) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .launch   (launch),
        .drop     (drop),
        .cmd_op   (cmd_op),
        .cmd_addr (cmd_addr),
        .mem_cmd  (mem_cmd),
        .mem_addr (mem_addr)
    );

    ddr_tx_wpath #(.DQ_W(DQ_W)) u_wpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .cmd_wdata (cmd_wdata),
        .oe_on     (oe_on),
        .oe_off    (oe_off),
        .beat_load (beat_load),
        .beat_idx  (beat_idx),
        .dqs_tgl   (dqs_tgl),
        .dq_o      (dq_o),
        .dq_oe     (dq_oe),
        .dqs_o     (dqs_o),
        .dqs_oe    (dqs_oe)
    );
endmodule

// File: rtl/ddr_wr_launch_chk.sv
`timescale 1ns/1ps
module ddr_wr_launch_chk #(
    parameter int DQ_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mem_ck,
    input logic [2:0]      mem_cmd,
    input logic [DQ_W-1:0] dq_o,
    input logic            dq_oe,
    input logic            dqs_o,
    input logic            dqs_oe
);
    logic [1:0] age;
    logic       armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            age <= 2'd0;
        else if (age != 2'd3)  age <= age + 2'd1;
    end
    assign armed = (age == 2'd3);

    // R2
    ck_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && mem_ck == $past(mem_ck)) |-> (mem_ck != $past(mem_ck, 2)));

    // R3
    cmd_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && mem_cmd != $past(mem_cmd)) |-> ($past(mem_ck) && !mem_ck));

    // R6
    dqs_on_ck_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && dqs_o != $past(dqs_o)) |-> (mem_ck != $past(mem_ck)));

    // R7
    dq_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && dq_o != $past(dq_o)) |-> (mem_ck == $past(mem_ck)));

    // R5
    preamble_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dqs_oe) |-> (!dqs_o && mem_ck));

    // R8
    postamble_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dqs_oe) |-> (!$past(dqs_o) && !$past(mem_ck)));

    // R9
    oe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe == dqs_oe);

    // R9
    released_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dqs_oe |-> !dqs_o);
endmodule

bind ddr_wr_launch ddr_wr_launch_chk #(.DQ_W(DQ_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mem_ck  (mem_ck),
    .mem_cmd (mem_cmd),
    .dq_o    (dq_o),
    .dq_oe   (dq_oe),
    .dqs_o   (dqs_o),
    .dqs_oe  (dqs_oe)
);

// File: tb/ddr_wr_launch_bench.sv
`timescale 1ns/1ps
module ddr_wr_launch_bench;
    localparam int ADDR_W = 13;
    localparam int DQ_W   = 8;
    localparam int NB     = 8;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 cmd_valid = 1'b0;
    logic [2:0]           cmd_op = 3'b111;
    logic [ADDR_W-1:0]    cmd_addr = '0;
    logic [1:0]           cmd_bl = 2'd0;
    logic [NB*DQ_W-1:0]   cmd_wdata = '0;
    logic                 mem_ck;
    logic [2:0]           mem_cmd;
    logic [ADDR_W-1:0]    mem_addr;
    logic [DQ_W-1:0]      dq_o;
    logic                 dq_oe, dqs_o, dqs_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [2:0]        exp_op[$];
    logic [ADDR_W-1:0] exp_addr[$];
    logic [DQ_W-1:0]   exp_beat[$];
    int                exp_bl[$];

    always #4 clk = ~clk;

    ddr_wr_launch #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_ddr_wr_launch (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_bl(cmd_bl), .cmd_wdata(cmd_wdata),
        .mem_ck(mem_ck), .mem_cmd(mem_cmd), .mem_addr(mem_addr),
        .dq_o(dq_o), .dq_oe(dq_oe), .dqs_o(dqs_o), .dqs_oe(dqs_oe)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: offers one command and records what should come out
    task automatic issue(input logic [2:0] op, input logic [ADDR_W-1:0] a,
                         input logic [1:0] bl, input logic [NB*DQ_W-1:0] wd,
                         input bit taken);
        int nb;
        if (taken) begin
            exp_op.push_back(op);
            exp_addr.push_back(a);
            if (op == 3'b100) begin
                nb = (bl == 2'd0) ? 2 : (bl == 2'd1) ? 4 : 8;
                for (int k = 0; k < nb; k++) exp_beat.push_back(wd[k*DQ_W +: DQ_W]);
                exp_bl.push_back(nb);
            end
        end
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_bl = bl; cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'b111;
    endtask

    task automatic check_idle(input string req);
        chk(!dq_oe && !dqs_oe, req, {dq_oe, dqs_oe}, 0);
    endtask

    // monitor / scoreboard
    bit         mon_on = 1'b0;
    logic       p_ck, p_dqs, p_oe;
    logic [2:0] p_cmd;
    int ck_run = 0, ck_tr = 0, cmd_run = 0;
    int since_wr = 0, since_oe = 0, since_edge = 0, edges = 0;
    bit wr_pend = 1'b0, first_pend = 1'b0;

    always @(negedge clk) begin
        if (!rst_n) begin
            mon_on = 1'b0;
        end else if (!mon_on) begin
            mon_on = 1'b1;
            p_ck = mem_ck; p_dqs = dqs_o; p_oe = dqs_oe; p_cmd = mem_cmd;
            ck_run = 1;
        end else begin
            if (wr_pend) since_wr++;
            if (p_oe) begin since_oe++; since_edge++; end
            cmd_run++;

            if (mem_ck != p_ck) begin
                if (ck_tr >= 1) chk(ck_run == 2, "R2 clock half-period", ck_run, 2);
                ck_tr++;
                ck_run = 1;
            end else ck_run++;

            if (mem_cmd != p_cmd) begin
                chk(p_ck && !mem_ck, "R3 command edge", {p_ck, mem_ck}, 2'b10);
                if (mem_cmd == 3'b111) begin
                    chk(cmd_run == 4, "R3 command hold", cmd_run, 4);
                end else begin
                    cmd_run = 0;
                    if (exp_op.size() == 0) begin
                        chk(1'b0, "R10 unexpected command", mem_cmd, 3'b111);
                    end else begin
                        logic [2:0] eo;
                        logic [ADDR_W-1:0] ea;
                        eo = exp_op.pop_front();
                        ea = exp_addr.pop_front();
                        chk(mem_cmd == eo, "R4 opcode", mem_cmd, eo);
                        chk(mem_addr == ea, "R4 address", mem_addr, ea);
                    end
                    if (mem_cmd == 3'b100) begin since_wr = 0; wr_pend = 1'b1; end
                end
            end

            chk(dq_oe == dqs_oe, "R9 enable pair", {dq_oe, dqs_oe}, {dqs_oe, dqs_oe});

            if (dqs_oe && !p_oe) begin
                chk(wr_pend && since_wr == 2, "R5 enable latency", since_wr, 2);
                chk(!dqs_o, "R5 preamble low", dqs_o, 0);
                wr_pend = 1'b0; since_oe = 0; edges = 0; first_pend = 1'b1;
            end else if (dqs_oe && dqs_o != p_dqs) begin
                chk(mem_ck != p_ck, "R6 strobe on clock edge", mem_ck, ~p_ck);
                chk(dqs_o == ((edges % 2) == 0), "R6 strobe direction", dqs_o, (edges % 2) == 0);
                if (first_pend) begin
                    chk(since_oe == 4, "R5 preamble length", since_oe, 4);
                    first_pend = 1'b0;
                end
                if (exp_beat.size() == 0) begin
                    chk(1'b0, "R7 extra strobe edge", edges, 0);
                end else begin
                    logic [DQ_W-1:0] eb;
                    eb = exp_beat.pop_front();
                    chk(dq_o == eb, "R7 beat at strobe edge", dq_o, eb);
                end
                edges++;
                since_edge = 0;
            end

            if (!dqs_oe && p_oe) begin
                int ebl;
                chk(since_edge == 2, "R8 postamble length", since_edge, 2);
                chk(!p_dqs, "R8 postamble low", p_dqs, 0);
                ebl = (exp_bl.size() != 0) ? exp_bl.pop_front() : -1;
                chk(edges == ebl, "R6 edge count", edges, ebl);
            end

            p_ck = mem_ck; p_dqs = dqs_o; p_oe = dqs_oe; p_cmd = mem_cmd;
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset values
        chk(mem_cmd == 3'b111, "R1 command", mem_cmd, 3'b111);
        chk(!mem_ck, "R1 clock", mem_ck, 0);
        chk(!dqs_o, "R1 strobe", dqs_o, 0);
        chk(!dq_oe && !dqs_oe, "R1 enables", {dq_oe, dqs_oe}, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check_idle("R9 before traffic");

        // R4 non-write command
        issue(3'b011, 13'h123, 2'd0, '0, 1'b1);
        repeat (20) @(negedge clk);
        check_idle("R4 no strobe for activate");
        chk(exp_op.size() == 0, "R4 command seen", exp_op.size(), 0);

        // R6/R7 bursts of 2, 4, 8 beats, and code 3
        issue(3'b100, 13'h0a5, 2'd0, 64'h0000_0000_0000_5aa5, 1'b1);
        repeat (40) @(negedge clk);
        check_idle("R9 after burst of 2");
        issue(3'b100, 13'h1f0, 2'd1, 64'h0000_0000_ff00_ff00, 1'b1);
        repeat (40) @(negedge clk);
        check_idle("R9 after burst of 4");
        issue(3'b100, 13'h007, 2'd2, 64'h8040_2010_0804_0201, 1'b1);
        repeat (40) @(negedge clk);
        check_idle("R9 after burst of 8");
        issue(3'b100, 13'h1ff, 2'd3, 64'hf1e2_d3c4_b5a6_9788, 1'b1);
        repeat (40) @(negedge clk);
        check_idle("R9 after code-3 burst");

        // R10 command offered mid-burst is dropped
        issue(3'b100, 13'h0c3, 2'd2, 64'h0123_4567_89ab_cdef, 1'b1);
        repeat (6) @(negedge clk);
        issue(3'b011, 13'h0ee, 2'd0, '0, 1'b0);
        repeat (40) @(negedge clk);
        check_idle("R10 after ignored offer");
        chk(exp_op.size() == 0, "R10 command queue", exp_op.size(), 0);

        // back-to-back: non-write directly after a write
        issue(3'b100, 13'h055, 2'd1, 64'h0000_0000_c33c_a55a, 1'b1);
        repeat (30) @(negedge clk);
        issue(3'b010, 13'h400, 2'd0, '0, 1'b1);
        repeat (20) @(negedge clk);
        check_idle("R9 end of traffic");
        chk(exp_beat.size() == 0, "R7 beats consumed", exp_beat.size(), 0);
        chk(exp_bl.size() == 0, "R6 bursts closed", exp_bl.size(), 0);
        chk(exp_op.size() == 0, "R4 commands consumed", exp_op.size(), 0);
        finish_run();
    end
endmodule